// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of pin levels and decides, for every pin on its own, whether the pin has raised an interrupt. Each pin takes one trigger mode from five: falling edge, rising edge, either edge, active-low level or active-high level. The mode comes from the matching bit of three type planes. Pins that trigger latch a bit in a status register, and software clears that bit by writing a one to it. The bits that are both set and unmasked are OR-combined onto a single interrupt line.

The pins pass through one sample register. A second register holds the previous sample, and edges are found by comparing the two. Software reaches five word registers through a simple write port and a combinational read port, both addressed by byte offset. A level-triggered pin whose level stays active sets its status bit again in the cycle after it is cleared. When a fresh trigger and a clear of the same bit land in the same cycle, the trigger wins.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset every register (mask, the three type planes, status) reads zero, and `irq` is 0.
- R2: Writes take effect on the next clock edge and read back at the byte offsets mask 0x00, type0 0x04, type1 0x08, type2 0x0C. Status reads at 0x10. Any other offset reads zero.
- R3: A pin with type1=0, type2=0 and type0=0 sets its status bit on a high-to-low transition of its sample, and on nothing else.
- R4: A pin with type1=0, type2=0 and type0=1 sets its status bit on a low-to-high transition of its sample, and on nothing else.
- R5: A pin with type1=0 and type2=1 sets its status bit on any transition, whatever its type0 bit.
- R6: A pin with type1=1 is level-triggered, whatever its type2 bit: type0=1 is active-high and type0=0 is active-low. While the level stays active, the status bit sets again in the cycle after a clear.
- R7: A write to offset 0x10 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R8: A status bit can only be set while that pin's mask bit is 1. A trigger on a masked-off pin leaves status unchanged.
- R9: `irq` is 1 exactly when some status bit and its mask bit are both 1. Clearing the mask lowers `irq` without altering status.
- R10: If a trigger and a clearing write for the same bit occur in the same cycle, the bit is 1 afterwards.
- R11: A pin change that is stable before clock edge k is visible in status and `irq` after edge k+1, and not after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | WIDTH | Pin levels to be watched |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the register written |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 5 | Byte offset of the register read |
| rd_data | output | WIDTH | Combinational read data |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change applied at a falling edge shows up in status and `irq` two rising edges later: one edge loads the sample register and the next loads status. A register write is visible right after the edge that takes it, and a read returns data within the same cycle. The bench drives every stimulus at a falling edge and reads 1 ns later. Sweep results are sampled three falling edges after each pin change, so every stage has settled. The latency check samples the falling edges right after edge k and edge k+1. The check where a clear meets a new trigger places the write strobe so that the edge which takes the write is the same edge that latches the trigger.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_MASK   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_TYPE0  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_TYPE1  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_TYPE2  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 5'h10;

    typedef enum logic [2:0] {
        MODE_FALL,
        MODE_RISE,
        MODE_BOTH,
        MODE_LOW,
        MODE_HIGH
    } trig_mode_e;

    // level selection dominates; then the dual-edge plane; then polarity
    function automatic trig_mode_e decode_mode(input logic t2, input logic t1, input logic t0);
        trig_mode_e m;
        if (t1)      m = t0 ? MODE_HIGH : MODE_LOW;
        else if (t2) m = MODE_BOTH;
        else         m = t0 ? MODE_RISE : MODE_FALL;
        return m;
    endfunction

endpackage

// File: rtl/pid_regs.sv
module pid_regs
    import pid_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  type0_q,
    output logic [WIDTH-1:0]  type1_q,
    output logic [WIDTH-1:0]  type2_q,
    output logic [WIDTH-1:0]  clr_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            type0_q <= '0;
            type1_q <= '0;
            type2_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFF_MASK:  mask_q  <= wr_data;
                OFF_TYPE0: type0_q <= wr_data;
                OFF_TYPE1: type1_q <= wr_data;
                OFF_TYPE2: type2_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_mask = '0;
        if (wr_en && wr_addr == OFF_STATUS) clr_mask = wr_data;
    end

endmodule

// File: rtl/pid_detect.sv
module pid_detect
    import pid_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] type0_q,
    input  logic [WIDTH-1:0] type1_q,
    input  logic [WIDTH-1:0] type2_q,
    output logic [WIDTH-1:0] cur_q,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= pin_in;
            prev_q <= cur_q;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        trig_mode_e mode;
        logic       hit_bit;

        always_comb begin
            mode = decode_mode(type2_q[i], type1_q[i], type0_q[i]);
            unique case (mode)
                MODE_FALL: hit_bit = prev_q[i] & ~cur_q[i];
                MODE_RISE: hit_bit = ~prev_q[i] & cur_q[i];
                MODE_BOTH: hit_bit = prev_q[i] ^ cur_q[i];
                MODE_LOW:  hit_bit = ~cur_q[i];
                MODE_HIGH: hit_bit = cur_q[i];
                default:   hit_bit = 1'b0;
            endcase
        end

        assign hit[i] = hit_bit;
    end

endmodule

// File: rtl/pid_status.sv
module pid_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic [WIDTH-1:0] mask_q,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status_q
);

    // a trigger in the clearing cycle is applied after the clear, so it survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | (hit & mask_q);
    end

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
    import pid_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              irq
);

    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] type0_q;
    logic [WIDTH-1:0] type1_q;
    logic [WIDTH-1:0] type2_q;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] status_q;

    pid_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mask_q   (mask_q),
        .type0_q  (type0_q),
        .type1_q  (type1_q),
        .type2_q  (type2_q),
        .clr_mask (clr_mask)
    );

    pid_detect #(.WIDTH(WIDTH)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .type0_q (type0_q),
        .type1_q (type1_q),
        .type2_q (type2_q),
        .cur_q   (cur_q),
        .hit     (hit)
    );

    pid_status #(.WIDTH(WIDTH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .mask_q   (mask_q),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    always_comb begin
        case (rd_addr)
            OFF_MASK:   rd_data = mask_q;
            OFF_TYPE0:  rd_data = type0_q;
            OFF_TYPE1:  rd_data = type1_q;
            OFF_TYPE2:  rd_data = type2_q;
            OFF_STATUS: rd_data = status_q;
            default:    rd_data = '0;
        endcase
    end

    assign irq = |(status_q & mask_q);

endmodule

// File: rtl/pid_checker.sv
module pid_checker
    import pid_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  mask_q,
    input logic [WIDTH-1:0]  type0_q,
    input logic [WIDTH-1:0]  type1_q,
    input logic [WIDTH-1:0]  cur_q,
    input logic [WIDTH-1:0]  hit,
    input logic [WIDTH-1:0]  status_q,
    input logic              irq
);

    logic [WIDTH-1:0] clr_seen;
    assign clr_seen = (wr_en && wr_addr == OFF_STATUS) ? wr_data : '0;

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_MASK) |=> (mask_q == $past(wr_data)));

    assert_clear_needs_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_seen)) == '0));

    assert_set_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_q & ~$past(status_q)) & ~$past(mask_q)) == '0));

    assert_trigger_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit & mask_q) & ~status_q) == '0));

    assert_level_high_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mask_q & type1_q & type0_q & cur_q) & ~status_q) == '0));

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

endmodule

bind pin_irq_detector pid_checker #(.WIDTH(WIDTH)) u_pid_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mask_q   (mask_q),
    .type0_q  (type0_q),
    .type1_q  (type1_q),
    .cur_q    (cur_q),
    .hit      (hit),
    .status_q (status_q),
    .irq      (irq)
);

// File: tb/pin_irq_detector_bench.sv
module pin_irq_detector_bench;

    localparam int W  = 8;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_MASK = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                              A_T2 = 5'h0C, A_ST = 5'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  pin_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pin_irq_detector #(.WIDTH(W)) u_pin_irq_detector (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pin i carries trigger code i: bit0 = type0, bit1 = type1, bit2 = type2
    function automatic logic [W-1:0] trig(input logic [W-1:0] p, input logic [W-1:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic [2:0] code;
            code = 3'(i);
            if (code[1])      r[i] = code[0] ? c[i] : ~c[i];
            else if (code[2]) r[i] = p[i] ^ c[i];
            else if (code[0]) r[i] = ~p[i] & c[i];
            else              r[i] = p[i] & ~c[i];
        end
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] cur;
        logic [W-1:0] nxt;
        logic [W-1:0] exp;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_MASK, v); check("R1 mask", v, '0);
        rd(A_T0, v);   check("R1 type0", v, '0);
        rd(A_T1, v);   check("R1 type1", v, '0);
        rd(A_T2, v);   check("R1 type2", v, '0);
        rd(A_ST, v);   check("R1 status", v, '0);
        check("R1 irq", {7'd0, irq}, 8'd0);

        // R2 write / read back
        wr(A_MASK, 8'h5A); rd(A_MASK, v); check("R2 mask", v, 8'h5A);
        wr(A_T0, 8'h3C);   rd(A_T0, v);   check("R2 type0", v, 8'h3C);
        wr(A_T1, 8'h81);   rd(A_T1, v);   check("R2 type1", v, 8'h81);
        wr(A_T2, 8'hE7);   rd(A_T2, v);   check("R2 type2", v, 8'hE7);
        rd(5'h14, v);                     check("R2 unmapped", v, 8'h00);

        // every trigger code on its own pin
        wr(A_MASK, 8'h00);
        wr(A_T0, 8'hAA);
        wr(A_T1, 8'hCC);
        wr(A_T2, 8'hF0);
        wr(A_ST, 8'hFF);
        wr(A_MASK, 8'hFF);
        idle(3);
        cur = '0;
        exp = trig(cur, cur);
        rd(A_ST, v); check("R6 level low at start", v, exp);
        wr(A_ST, 8'hFF);
        idle(3);
        rd(A_ST, v); check("R6 level re-set after clear", v, exp);

        // sweep of pin patterns
        for (int k = 0; k < 24; k++) begin
            case (k)
                0: nxt = 8'hFF;
                1: nxt = 8'h00;
                2: nxt = 8'hAA;
                3: nxt = 8'h55;
                4: nxt = 8'h00;
                default: nxt = 8'(k * 77 + 23);
            endcase
            @(negedge clk);
            pin_in = nxt;
            idle(3);
            exp = exp | trig(cur, nxt);
            rd(A_ST, v); check("R3/R4/R5/R6 sweep status", v, exp);
            check("R9 sweep irq", {7'd0, irq}, {7'd0, |exp});
            cur = nxt;
            wr(A_ST, 8'hFF);
            idle(3);
            exp = trig(cur, cur);
            rd(A_ST, v); check("R7/R6 sweep after clear", v, exp);
        end

        // R11 latency
        @(negedge clk); pin_in = 8'h00;
        idle(3);
        wr(A_ST, 8'hFF);
        idle(3);
        @(negedge clk); pin_in = 8'h02;          // pin 1 rising edge
        @(negedge clk);
        rd(A_ST, v); check("R11 not after first edge", v & 8'h02, 8'h00);
        @(negedge clk);
        rd(A_ST, v); check("R11 set after second edge", v & 8'h02, 8'h02);
        check("R11 irq", {7'd0, irq}, 8'd1);

        // R10 trigger and clear in the same cycle (pin 5, either edge)
        @(negedge clk); pin_in = 8'h22;
        idle(3);
        rd(A_ST, v); check("R5 both-edge set", v, 8'h66);
        @(negedge clk); pin_in = 8'h02;
        @(negedge clk); wr_en = 1'b1; wr_addr = A_ST; wr_data = 8'h20;
        @(negedge clk); wr_en = 1'b0;
        rd(A_ST, v); check("R10 trigger beats clear", v, 8'h66);
        wr(A_ST, 8'h20);
        idle(2);
        rd(A_ST, v); check("R10 control clear", v, 8'h46);

        // R7 write-one-to-clear
        wr(A_ST, 8'h00);
        rd(A_ST, v); check("R7 zero write keeps", v, 8'h46);
        wr(A_ST, 8'h02);
        rd(A_ST, v); check("R7 partial clear", v, 8'h44);

        // R8 masked pin
        wr(A_ST, 8'hFF);
        wr(A_MASK, 8'hDF);
        idle(3);
        @(negedge clk); pin_in = 8'h22;
        idle(3);
        rd(A_ST, v); check("R8 masked pin ignored", v, 8'h44);

        // R9 mask gates irq only
        wr(A_MASK, 8'h00);
        idle(2);
        check("R9 irq low with mask 0", {7'd0, irq}, 8'd0);
        rd(A_ST, v); check("R9 status kept", v, 8'h44);
        wr(A_MASK, 8'h40);
        check("R9 irq high with mask", {7'd0, irq}, 8'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule